// File: doc/BRIEF.md
# UART Interrupt Status and Masking Unit

This block gathers the eleven interrupt causes of a UART into one sticky raw status vector. A mask register selects which causes may reach the processor. The unit gives three views: the raw vector, the mask, and the masked vector, which is the raw vector ANDed with the mask. The OR of the masked vector drives a single registered interrupt line. Software removes a cause by writing ones to the clear strobe, one bit for each cause.

Two of the causes are not event pulses. The receive cause is raised while the receive FIFO fill count is at or above a programmable threshold. The transmit cause is raised while the transmit fill count is at or below its own threshold. Each threshold is chosen by a 3-bit level code held in a small level register.

The block carries no data stream. All of its pins are plain control and status signals: single-cycle write strobes, event pulses and fill counts. There is no valid/ready handshake and no back-pressure, and every strobe takes effect at the next clock edge.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is active, and at the first sample after it, the raw vector, the mask and the interrupt line are all zero and both level codes are 000.
- R2: The cause bits are: overrun 10, break 9, parity 8, framing 7, receive timeout 6, transmit 5, receive 4, DSR 3, DCD 2, CTS 1, ring indicator 0. A pulse on `evt_pulse[i]` for any i other than 4 and 5 sets raw bit i at the next edge, and the bit stays set until it is cleared.
- R3: When `clr_wr` is high, each 1 in `clr_wdata` clears the matching raw bit at the next edge. A 0 leaves its bit unchanged. If a set and a clear hit the same bit in the same cycle, the bit stays set.
- R4: `mask_wr` loads `mask_wdata` into the mask at the next edge. `masked_stat` equals `raw_stat` AND the mask, so a mask bit of 1 enables its cause.
- R5: `irq` is the OR of all `masked_stat` bits, registered, so it follows `masked_stat` one cycle later.
- R6: `lvl_wr` loads the level register. The receive code is `lvl_wdata[5:3]` and the transmit code is `lvl_wdata[2:0]`. With a 32-entry FIFO, the codes 000, 001, 010, 011 and 100 give thresholds of 4, 8, 16, 24 and 28 entries. The codes 101, 110 and 111 act as 100.
- R7: Raw bit 4 (receive) is set at an edge when `rx_count` is at or above the receive threshold. Raw bit 5 (transmit) is set at an edge when `tx_count` is at or below the transmit threshold. Both comparisons use the level codes held before that edge.
- R8: `evt_pulse[4]` and `evt_pulse[5]` are ignored. They do not change raw bits 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 11 | Single-cycle cause pulses, one for each raw bit |
| rx_count | input | 6 | Receive FIFO fill count, 0 to 32 |
| tx_count | input | 6 | Transmit FIFO fill count, 0 to 32 |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 11 | New mask value |
| clr_wr | input | 1 | Clear strobe |
| clr_wdata | input | 11 | Bits to clear (write-one-to-clear) |
| lvl_wr | input | 1 | Level register write strobe |
| lvl_wdata | input | 6 | Receive code [5:3], transmit code [2:0] |
| raw_stat | output | 11 | Raw sticky status |
| mask_q | output | 11 | Current mask |
| masked_stat | output | 11 | Raw status AND mask |
| irq | output | 1 | Registered OR of the masked status |

## Verification
The assertions assume that the fill counts never exceed the FIFO depth. They also assume that the strobes and pulses are synchronous and last one cycle. The bench drives each count only within 0 to 32 and changes every input just after a falling edge. When the bench tests a clear of a FIFO-driven bit, it moves the count across the threshold in the same cycle as the clear. This is needed because the set-wins rule would otherwise keep the bit set.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int unsigned NSRC     = 11;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned IDX_OVR  = 10;
  localparam int unsigned IDX_BRK  = 9;
  localparam int unsigned IDX_PAR  = 8;
  localparam int unsigned IDX_FRM  = 7;
  localparam int unsigned IDX_RTO  = 6;
  localparam int unsigned IDX_TX   = 5;
  localparam int unsigned IDX_RX   = 4;
  localparam int unsigned IDX_DSR  = 3;
  localparam int unsigned IDX_DCD  = 2;
  localparam int unsigned IDX_CTS  = 1;
  localparam int unsigned IDX_RING = 0;

  typedef enum logic [CODE_W-1:0] {
    LVL_EIGHTH   = 3'd0,
    LVL_QUARTER  = 3'd1,
    LVL_HALF     = 3'd2,
    LVL_3QUARTER = 3'd3,
    LVL_7EIGHTH  = 3'd4
  } lvl_code_e;
endpackage

// File: rtl/uirq_thresh.sv
module uirq_thresh
  import uirq_pkg::*;
#(
  parameter int unsigned DEPTH     = 32,
  parameter bit          AT_ABOVE  = 1'b1,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CNT_W-1:0]  count,
  output logic              hit
);
  logic [CNT_W-1:0] thr;

  // codes past the last defined one saturate at seven-eighths
  always_comb begin
    case (code)
      LVL_EIGHTH:   thr = CNT_W'(DEPTH / 8);
      LVL_QUARTER:  thr = CNT_W'(DEPTH / 4);
      LVL_HALF:     thr = CNT_W'(DEPTH / 2);
      LVL_3QUARTER: thr = CNT_W'((DEPTH * 3) / 4);
      default:      thr = CNT_W'((DEPTH * 7) / 8);
    endcase
  end

  generate
    if (AT_ABOVE) begin : g_fill
      assign hit = (count >= thr);
    end else begin : g_drain
      assign hit = (count <= thr);
    end
  endgenerate
endmodule

// File: rtl/uirq_raw_bank.sv
module uirq_raw_bank #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] raw
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)          raw[i] <= 1'b0;
        else if (set_vec[i]) raw[i] <= 1'b1;   // set beats clear
        else if (clr_vec[i]) raw[i] <= 1'b0;
      end
    end
  endgenerate

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((raw & $past(set_vec)) == $past(set_vec))); // R2

  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((($past(raw) & ~raw) & ~$past(clr_vec)) == '0)); // R3
endmodule

// File: rtl/uirq_mask_out.sv
module uirq_mask_out #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] masked,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  assign masked = raw & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |masked;
  end

  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(mask_wdata))); // R4

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|masked) |=> irq); // R5

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|masked) |=> !irq); // R5
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_pulse,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              mask_wr,
  input  logic [NSRC-1:0]   mask_wdata,
  input  logic              clr_wr,
  input  logic [NSRC-1:0]   clr_wdata,
  input  logic              lvl_wr,
  input  logic [2*CODE_W-1:0] lvl_wdata,
  output logic [NSRC-1:0]   raw_stat,
  output logic [NSRC-1:0]   mask_q,
  output logic [NSRC-1:0]   masked_stat,
  output logic              irq
);
  localparam logic [NSRC-1:0] FIFO_SRC = (NSRC'(1) << IDX_RX) | (NSRC'(1) << IDX_TX);

  logic [CODE_W-1:0] rx_code, tx_code;
  logic              rx_hit, tx_hit;
  logic [NSRC-1:0]   set_vec, clr_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_code <= '0;
      tx_code <= '0;
    end else if (lvl_wr) begin
      rx_code <= lvl_wdata[2*CODE_W-1:CODE_W];
      tx_code <= lvl_wdata[CODE_W-1:0];
    end
  end

  uirq_thresh #(.DEPTH(DEPTH), .AT_ABOVE(1'b1)) u_rx_thr (
    .code(rx_code), .count(rx_count), .hit(rx_hit));
  uirq_thresh #(.DEPTH(DEPTH), .AT_ABOVE(1'b0)) u_tx_thr (
    .code(tx_code), .count(tx_count), .hit(tx_hit));

  always_comb begin
    set_vec          = evt_pulse & ~FIFO_SRC;
    set_vec[IDX_RX]  = rx_hit;
    set_vec[IDX_TX]  = tx_hit;
  end

  assign clr_vec = clr_wr ? clr_wdata : '0;

  uirq_raw_bank #(.N(NSRC)) u_raw (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .raw(raw_stat));

  uirq_mask_out #(.N(NSRC)) u_out (
    .clk(clk), .rst_n(rst_n), .raw(raw_stat), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .mask_q(mask_q), .masked(masked_stat), .irq(irq));

  AST_RX_FULLISH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count >= CNT_W'((DEPTH * 7) / 8)) |=> raw_stat[IDX_RX]); // R7

  AST_TX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CNT_W'(DEPTH / 8)) |=> raw_stat[IDX_TX]); // R7

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CNT_W'(DEPTH)) && (tx_count <= CNT_W'(DEPTH))); // R6
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] evt_pulse = '0, mask_wdata = '0, clr_wdata = '0;
  logic [5:0] rx_count = '0, tx_count = 6'd16, lvl_wdata = '0;
  logic mask_wr = 1'b0, clr_wr = 1'b0, lvl_wr = 1'b0;
  logic [N-1:0] raw_stat, mask_q, masked_stat;
  logic irq;

  int n_checks = 0, n_errors = 0;

  typedef struct {
    logic [N-1:0] raw;
    logic [N-1:0] mask;
    logic         irq;
    string        tag;
  } exp_t;
  exp_t sb[$];

  logic [N-1:0] m_raw = '0, m_mask = '0;
  logic [5:0]   m_lvl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .rx_count(rx_count),
    .tx_count(tx_count), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata), .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
    .raw_stat(raw_stat), .mask_q(mask_q), .masked_stat(masked_stat), .irq(irq));

  function automatic int thr_of(input logic [2:0] c);
    case (c)
      3'd0: return 4;
      3'd1: return 8;
      3'd2: return 16;
      3'd3: return 24;
      default: return 28;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected outcome
  task automatic step(input logic [N-1:0] evt, input logic cw, input logic [N-1:0] cd,
                      input logic mw, input logic [N-1:0] md, input logic lw, input logic [5:0] ld,
                      input logic [5:0] rxc, input logic [5:0] txc, input string tag);
    exp_t e;
    logic [N-1:0] nraw;
    evt_pulse = evt; clr_wr = cw; clr_wdata = cd; mask_wr = mw; mask_wdata = md;
    lvl_wr = lw; lvl_wdata = ld; rx_count = rxc; tx_count = txc;
    nraw = cw ? (m_raw & ~cd) : m_raw;
    nraw = nraw | (evt & ~11'h030);
    if (int'(rxc) >= thr_of(m_lvl[5:3])) nraw[4] = 1'b1;
    if (int'(txc) <= thr_of(m_lvl[2:0])) nraw[5] = 1'b1;
    e.irq = |(m_raw & m_mask);
    m_raw = nraw;
    if (mw) m_mask = md;
    if (lw) m_lvl = ld;
    e.raw = m_raw; e.mask = m_mask; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic [5:0] rxc, input logic [5:0] txc, input string tag);
    step('0, 1'b0, '0, 1'b0, '0, 1'b0, '0, rxc, txc, tag);
  endtask

  // monitor: compare each queued expectation at the falling edge after its rising edge
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "raw_stat", 32'(raw_stat), 32'(e.raw));
        check(e.tag, "mask_q", 32'(mask_q), 32'(e.mask));
        check(e.tag, "masked_stat", 32'(masked_stat), 32'(e.raw & e.mask));
        check(e.tag, "irq", 32'(irq), 32'(e.irq));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "raw in reset", 32'(raw_stat), 0);
    check("R1", "mask in reset", 32'(mask_q), 0);
    check("R1", "irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
    // R1: first sample after reset, counts away from both thresholds
    idle(6'd0, 6'd16, "R1");
    // R2: overrun then ring indicator, sticky
    step(11'h400, 0, '0, 0, '0, 0, '0, 6'd0, 6'd16, "R2");
    idle(6'd0, 6'd16, "R2");
    step(11'h001, 0, '0, 0, '0, 0, '0, 6'd0, 6'd16, "R2");
    step(11'h1CE, 0, '0, 0, '0, 0, '0, 6'd0, 6'd16, "R2");
    // R8: pulses on the FIFO-driven bits do nothing
    step(11'h030, 0, '0, 0, '0, 0, '0, 6'd0, 6'd16, "R8");
    idle(6'd0, 6'd16, "R8");
    // R4 / R5: enable overrun and ring
    step('0, 0, '0, 1, 11'h401, 0, '0, 6'd0, 6'd16, "R4");
    idle(6'd0, 6'd16, "R5");
    idle(6'd0, 6'd16, "R5");
    // R3: clear overrun, zeros untouched
    step('0, 1, 11'h400, 0, '0, 0, '0, 6'd0, 6'd16, "R3");
    // R3: set and clear together on ring: stays set
    step(11'h001, 1, 11'h001, 0, '0, 0, '0, 6'd0, 6'd16, "R3");
    step('0, 1, 11'h7FF, 0, '0, 0, '0, 6'd0, 6'd16, "R3");
    idle(6'd0, 6'd16, "R5");
    idle(6'd0, 6'd16, "R5");
    // R7: receive at threshold 4 with code 000
    step('0, 0, '0, 1, 11'h030, 0, '0, 6'd3, 6'd16, "R7");
    step('0, 0, '0, 0, '0, 0, '0, 6'd4, 6'd16, "R7");
    step('0, 1, 11'h010, 0, '0, 0, '0, 6'd3, 6'd16, "R7");
    // R6: receive code 010 -> 16, transmit code 001 -> 8
    step('0, 0, '0, 0, '0, 1, 6'b010_001, 6'd0, 6'd16, "R6");
    step('0, 0, '0, 0, '0, 0, '0, 6'd15, 6'd9, "R6");
    step('0, 0, '0, 0, '0, 0, '0, 6'd16, 6'd9, "R6");
    step('0, 1, 11'h010, 0, '0, 0, '0, 6'd0, 6'd8, "R7");
    step('0, 1, 11'h020, 0, '0, 0, '0, 6'd0, 6'd9, "R7");
    // R6: reserved receive code 111 acts as 28, transmit code 100 -> 28
    step('0, 0, '0, 0, '0, 1, 6'b111_100, 6'd0, 6'd32, "R6");
    step('0, 0, '0, 0, '0, 0, '0, 6'd27, 6'd29, "R6");
    step('0, 0, '0, 0, '0, 0, '0, 6'd28, 6'd29, "R6");
    step('0, 1, 11'h010, 0, '0, 0, '0, 6'd0, 6'd28, "R6");
    // R6: transmit code 011 -> 24, receive code 011 -> 24
    step('0, 1, 11'h020, 0, '0, 1, 6'b011_011, 6'd0, 6'd32, "R6");
    step('0, 0, '0, 0, '0, 0, '0, 6'd24, 6'd25, "R6");
    step('0, 0, '0, 0, '0, 0, '0, 6'd0, 6'd24, "R6");
    // R4: mask change with raw held
    step('0, 0, '0, 1, 11'h000, 0, '0, 6'd0, 6'd32, "R4");
    idle(6'd0, 6'd32, "R5");
    idle(6'd0, 6'd32, "R5");
    check("R3", "scoreboard drained", 32'(sb.size()), 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule